// File: doc/BRIEF.md
# Debug Pin Ownership Arbiter

This block decides who drives the two data pins of a four-wire test port: the general-purpose I/O logic or the debug port. It sits between the combined two-wire/four-wire debug port and the pin multiplexer. After reset the port is in four-wire mode, but the data pins still belong to GPIO, so the chip looks as if it came up in two-wire mode.

The debug clock and mode-select lines pass through two-flop synchronisers into the system clock. The mode-select value is sampled on each rising edge of the debug clock. The switch sequence has three parts: at least 50 clocks with mode-select high, then the 16-bit value 0xE79E sent least significant bit first, then at least 50 more high clocks. When the sequence completes, the port moves to two-wire mode and the pins stay with GPIO. Any other activity while in four-wire mode hands both pins to the debug port. This covers a low bit too early, a wrong pattern bit, or a low bit before the trailing high run ends. That ownership latch is sticky until a debug-side reset.

Software can pre-arm a per-pin override that keeps a pin with GPIO even after a takeover. A write to the override while the latch is set is refused with a bus error. A topology input selects whether the external reset pin also clears the debug-side mode and latch. The register port is a plain request/acknowledge interface with no back-pressure: every request is accepted and answered exactly one cycle later.

Top module: `dbg_pin_owner`

## Requirements
- R1: After `rst_n` the port is in four-wire mode, the ownership latch is clear, the override is 0 and `pin_to_dbg` is all zero.
- R2: A complete sequence moves the port to two-wire mode (status bit 0 = 1) and leaves the latch unchanged. The sequence is at least 50 rising debug clocks with mode-select high, then 0xE79E sent LSB first, then at least 50 high clocks. The move happens on the 50th trailing high.
- R3: In four-wire mode, any sampled bit that departs from the sequence sets the latch (status bit 1). This includes a low before 50 leading highs, a wrong pattern bit, or a low before the 50th trailing high.
- R4: In two-wire mode, debug line activity never sets the latch.
- R5: Once set, the latch stays set through any debug traffic, including a later complete switch sequence. Only `rst_n`, or an external reset with the topology input high, clears it.
- R6: `pin_to_dbg[i]` is 1 exactly when the latch is set and override bit i is 0. The status read reports `pin_to_dbg` in bits [3:2].
- R7: A write to the override register (address 1) while the latch is set returns `reg_err` = 1 and leaves the override unchanged. When the latch is clear, the write succeeds with `reg_err` = 0.
- R8: A cycle with `ext_rst_n` low always clears the override. It also clears the mode and the latch only when `topo_sel` is 1; with `topo_sel` 0 they are kept.
- R9: `reg_ack` is high exactly one cycle after each cycle with `reg_en` high. Reads of address 0 return status {pin_to_dbg, latch, two-wire}; reads of address 1 return the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Full chip and debug reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, sampled synchronously |
| topo_sel | input | 1 | 1: external reset also clears debug-side state |
| dbg_clk_i | input | 1 | Debug clock line, asynchronous |
| dbg_mode_i | input | 1 | Debug mode-select line, asynchronous |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 write, 0 read |
| reg_addr | input | 1 | 0 status (read only), 1 override |
| reg_wdata | input | NPIN | Override write value |
| reg_ack | output | 1 | Access answered, one cycle after request |
| reg_err | output | 1 | Bus error on refused override write |
| reg_rdata | output | NPIN+2 | Read data |
| pin_to_dbg | output | NPIN | Per pin: 1 debug port drives, 0 GPIO and alternate functions drive |

## Verification
The bench targets the edges of the high-count windows: exactly 50 leading and trailing highs, and 49 of either. A design with an off-by-one counter would either switch modes on a short sequence or take over on a legal one. A corrupted pattern bit must take the pins rather than quietly re-arm the detector. A completed switch after a takeover must not release the latch. With the latch set, a refused override write must leave the register unchanged. External resets are tried under both topology settings: clearing too much drops the latch when it should stick, and clearing too little leaves a stale override behind.

// File: rtl/dpo_pkg.sv
package dpo_pkg;

  typedef enum logic [1:0] {
    DET_HUNT = 2'd0,
    DET_PAT  = 2'd1,
    DET_POST = 2'd2,
    DET_DONE = 2'd3
  } det_state_e;

  localparam int unsigned STAT_TWO_WIRE_BIT = 0;
  localparam int unsigned STAT_OWNED_BIT    = 1;
  localparam int unsigned STAT_PIN_LSB      = 2;

endpackage

// File: rtl/dpo_sync.sv
module dpo_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dpo_seq_det.sv
module dpo_seq_det
  import dpo_pkg::*;
#(
  parameter int                 HIGH_MIN = 50,
  parameter int                 PAT_LEN  = 16,
  parameter logic [PAT_LEN-1:0] PATTERN  = 16'hE79E
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tck_s,
  input  logic tms_s,
  output logic two_wire_o,
  output logic owned_o
);

  localparam int CW = $clog2(HIGH_MIN + 1);
  localparam int IW = $clog2(PAT_LEN);

  logic          tck_d;
  logic          rise;
  det_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          two_q, two_n;
  logic          own_q, own_n;
  logic          mism;
  logic          exp_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tck_d <= 1'b0;
    else        tck_d <= tck_s;
  end

  assign rise    = tck_s & ~tck_d;
  assign exp_bit = PATTERN[idx_q];

  // The pattern's first bit is low, which is what ends the leading run.
  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    idx_n = idx_q;
    two_n = two_q;
    own_n = own_q;
    mism  = 1'b0;
    if (rise && !two_q) begin
      unique case (st_q)
        DET_HUNT: begin
          if (tms_s) begin
            if (cnt_q != CW'(HIGH_MIN)) cnt_n = cnt_q + CW'(1);
          end else if (cnt_q == CW'(HIGH_MIN)) begin
            st_n  = DET_PAT;
            idx_n = IW'(1);
            cnt_n = '0;
          end else begin
            mism = 1'b1;
          end
        end
        DET_PAT: begin
          if (tms_s == exp_bit) begin
            if (idx_q == IW'(PAT_LEN - 1)) begin
              st_n  = DET_POST;
              idx_n = '0;
              cnt_n = '0;
            end else begin
              idx_n = idx_q + IW'(1);
            end
          end else begin
            mism = 1'b1;
          end
        end
        DET_POST: begin
          if (tms_s) begin
            if (cnt_q == CW'(HIGH_MIN - 1)) begin
              st_n  = DET_DONE;
              two_n = 1'b1;
              cnt_n = '0;
            end else begin
              cnt_n = cnt_q + CW'(1);
            end
          end else begin
            mism = 1'b1;
          end
        end
        default: ;
      endcase
      if (mism) begin
        own_n = 1'b1;
        st_n  = DET_HUNT;
        cnt_n = '0;
        idx_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DET_HUNT;
      cnt_q <= '0;
      idx_q <= '0;
      two_q <= 1'b0;
      own_q <= 1'b0;
    end else if (clear) begin
      st_q  <= DET_HUNT;
      cnt_q <= '0;
      idx_q <= '0;
      two_q <= 1'b0;
      own_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      idx_q <= idx_n;
      two_q <= two_n;
      own_q <= own_n;
    end
  end

  assign two_wire_o = two_q;
  assign owned_o    = own_q;

  // R5: the latch never drops without a debug-side clear
  a_r5_owned_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    own_q && !clear |=> own_q);

  // R4: a takeover can only start from four-wire mode
  a_r4_take_in_four_wire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_q) |-> $past(!two_q));

  // R2: completing the switch does not alter ownership
  a_r2_switch_keeps_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(two_q) |-> $stable(own_q));

  // R8: a debug-side clear wipes mode and latch
  a_r8_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !two_q && !own_q);

endmodule

// File: rtl/dpo_ovr_regs.sv
module dpo_ovr_regs
  import dpo_pkg::*;
#(
  parameter int NPIN   = 2,
  parameter int STAT_W = NPIN + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_clear,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [NPIN-1:0]   reg_wdata,
  input  logic              owned,
  input  logic              two_wire,
  input  logic [NPIN-1:0]   pin_dbg,
  output logic [NPIN-1:0]   ovr_o,
  output logic              reg_ack,
  output logic              reg_err,
  output logic [STAT_W-1:0] reg_rdata
);

  logic [NPIN-1:0]   ovr_q;
  logic [STAT_W-1:0] status;
  logic              wr_ovr;

  always_comb begin
    status                    = '0;
    status[STAT_TWO_WIRE_BIT] = two_wire;
    status[STAT_OWNED_BIT]    = owned;
    status[STAT_PIN_LSB +: NPIN] = pin_dbg;
  end

  assign wr_ovr = reg_en && reg_we && reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q     <= '0;
      reg_ack   <= 1'b0;
      reg_err   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ack   <= reg_en;
      reg_err   <= wr_ovr && owned;
      reg_rdata <= '0;
      if (reg_en && !reg_we) reg_rdata <= reg_addr ? STAT_W'(ovr_q) : status;
      if (sys_clear)               ovr_q <= '0;
      else if (wr_ovr && !owned)   ovr_q <= reg_wdata;
    end
  end

  assign ovr_o = ovr_q;

  // R7: a refused write leaves the override untouched
  a_r7_err_keeps_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack && reg_err && $past(!sys_clear) |-> $stable(ovr_q));

  // R9: every request is answered on the next cycle
  a_r9_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |=> reg_ack);

  // R9: no answer without a request
  a_r9_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack |-> $past(reg_en));

endmodule

// File: rtl/dbg_pin_owner.sv
module dbg_pin_owner #(
  parameter int                 NPIN     = 2,
  parameter int                 HIGH_MIN = 50,
  parameter int                 PAT_LEN  = 16,
  parameter logic [PAT_LEN-1:0] PATTERN  = 16'hE79E,
  parameter int                 SYNC_N   = 2,
  localparam int                STAT_W   = NPIN + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst_n,
  input  logic              topo_sel,
  input  logic              dbg_clk_i,
  input  logic              dbg_mode_i,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [NPIN-1:0]   reg_wdata,
  output logic              reg_ack,
  output logic              reg_err,
  output logic [STAT_W-1:0] reg_rdata,
  output logic [NPIN-1:0]   pin_to_dbg
);

  logic [1:0]      lines_s;
  logic            dbg_clear;
  logic            sys_clear;
  logic            two_wire;
  logic            owned;
  logic [NPIN-1:0] ovr;

  dpo_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dbg_mode_i, dbg_clk_i}),
    .q     (lines_s)
  );

  assign sys_clear = ~ext_rst_n;
  assign dbg_clear = topo_sel & ~ext_rst_n;

  dpo_seq_det #(
    .HIGH_MIN (HIGH_MIN),
    .PAT_LEN  (PAT_LEN),
    .PATTERN  (PATTERN)
  ) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (dbg_clear),
    .tck_s      (lines_s[0]),
    .tms_s      (lines_s[1]),
    .two_wire_o (two_wire),
    .owned_o    (owned)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign pin_to_dbg[g] = owned & ~ovr[g];
  end

  dpo_ovr_regs #(.NPIN(NPIN), .STAT_W(STAT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_clear (sys_clear),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .owned     (owned),
    .two_wire  (two_wire),
    .pin_dbg   (pin_to_dbg),
    .ovr_o     (ovr),
    .reg_ack   (reg_ack),
    .reg_err   (reg_err),
    .reg_rdata (reg_rdata)
  );

endmodule

// File: tb/dbg_pin_owner_tb_top.sv
`timescale 1ns/1ps
module dbg_pin_owner_tb_top;

  localparam int NPIN   = 2;
  localparam int STAT_W = NPIN + 2;
  localparam logic [15:0] PAT = 16'hE79E;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ext_rst_n = 1'b1;
  logic              topo_sel = 1'b0;
  logic              dbg_clk_i = 1'b0;
  logic              dbg_mode_i = 1'b0;
  logic              reg_en = 1'b0;
  logic              reg_we = 1'b0;
  logic              reg_addr = 1'b0;
  logic [NPIN-1:0]   reg_wdata = '0;
  logic              reg_ack;
  logic              reg_err;
  logic [STAT_W-1:0] reg_rdata;
  logic [NPIN-1:0]   pin_to_dbg;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  logic            e_two, e_own;
  logic [NPIN-1:0] e_ovr;

  always #2.5 clk = ~clk;

  dbg_pin_owner dut_i (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .topo_sel(topo_sel),
    .dbg_clk_i(dbg_clk_i), .dbg_mode_i(dbg_mode_i),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata),
    .pin_to_dbg(pin_to_dbg)
  );

  function automatic logic [NPIN-1:0] exp_pins(logic own, logic [NPIN-1:0] ovr);
    return own ? ~ovr : '0;
  endfunction

  function automatic logic [STAT_W-1:0] exp_status(logic two, logic own, logic [NPIN-1:0] ovr);
    return {exp_pins(own, ovr), own, two};
  endfunction

  function automatic bit seq_clean(int pre, int flip, int post);
    return (pre >= 50) && (post >= 50) && (flip < 0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [STAT_W-1:0] d, output logic ack);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata; ack = reg_ack;
  endtask

  task automatic wr(input logic [NPIN-1:0] v, output logic err, output logic ack);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
    err = reg_err; ack = reg_ack;
  endtask

  task automatic check_state(string req);
    logic [STAT_W-1:0] d;
    logic ack;
    rd(1'b0, d, ack);
    chk({req, " status"}, 32'(d), 32'(exp_status(e_two, e_own, e_ovr)));
    chk("R9 ack on read", 32'(ack), 32'd1);
    chk({req, " pins"}, 32'(pin_to_dbg), 32'(exp_pins(e_own, e_ovr)));
    rd(1'b1, d, ack);
    chk({req, " override"}, 32'(d), 32'(e_ovr));
  endtask

  task automatic dbg_bit(input logic b);
    @(negedge clk); dbg_mode_i = b;
    repeat (2) @(negedge clk); dbg_clk_i = 1'b1;
    repeat (3) @(negedge clk); dbg_clk_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_seq(input int pre, input int flip, input int post, input bit trail);
    for (int i = 0; i < pre; i++) dbg_bit(1'b1);
    for (int i = 0; i < 16; i++) dbg_bit((i == flip) ? ~PAT[i] : PAT[i]);
    for (int i = 0; i < post; i++) dbg_bit(1'b1);
    if (trail) dbg_bit(1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic ext_pulse(input logic topo);
    @(negedge clk); topo_sel = topo; ext_rst_n = 1'b0;
    @(negedge clk); ext_rst_n = 1'b1;
    e_ovr = '0;
    if (topo) begin e_two = 1'b0; e_own = 1'b0; end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic err, ack;
    int pre, flip, post;
    logic [NPIN-1:0] v;
    void'($urandom(32'd20240611));
    e_two = 0; e_own = 0; e_ovr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 pins at reset", 32'(pin_to_dbg), 32'd0);
    check_state("R1");
    // R9 no ack while idle
    repeat (2) @(negedge clk);
    chk("R9 idle ack", 32'(reg_ack), 32'd0);

    // R2 minimum legal sequence
    send_seq(50, -1, 50, 1'b0);
    e_two = 1'b1;
    check_state("R2 minimum sequence");

    // R4 traffic in two-wire mode
    for (int i = 0; i < 24; i++) dbg_bit(1'($urandom_range(0, 1)));
    repeat (4) @(negedge clk);
    check_state("R4 two-wire traffic");

    // R8 topology-selected reset clears mode
    ext_pulse(1'b1);
    check_state("R8 topo reset");

    // R3 early low
    send_seq(10, -1, 0, 1'b0);
    e_own = 1'b1;
    check_state("R3 early low");

    // R7 refused write
    wr(2'b01, err, ack);
    chk("R7 err on owned write", 32'(err), 32'd1);
    chk("R9 ack on write", 32'(ack), 32'd1);
    check_state("R7 override unchanged");

    // R5 full sequence after takeover
    send_seq(60, -1, 55, 1'b0);
    e_two = 1'b1;
    check_state("R5 latch survives switch");

    // R8 external reset without topology keeps debug state
    ext_pulse(1'b0);
    check_state("R8 keep on topo0");

    // R6 pre-armed override
    ext_pulse(1'b1);
    wr(2'b10, err, ack);
    chk("R7 err when free", 32'(err), 32'd0);
    e_ovr = 2'b10;
    send_seq(3, -1, 0, 1'b1);
    e_own = 1'b1;
    check_state("R6 override holds pin");
    ext_pulse(1'b0);
    check_state("R8 override cleared");

    // R3 trailing run one short
    ext_pulse(1'b1);
    send_seq(55, -1, 49, 1'b1);
    e_own = 1'b1;
    check_state("R3 short trailing run");

    // R3 leading run one short
    ext_pulse(1'b1);
    send_seq(49, -1, 50, 1'b0);
    e_own = 1'b1;
    check_state("R3 short leading run");

    // R3 corrupted pattern bit (last one)
    ext_pulse(1'b1);
    send_seq(50, 15, 50, 1'b0);
    e_own = 1'b1;
    check_state("R3 corrupt pattern");

    // R2/R3 random mix
    for (int it = 0; it < 20; it++) begin
      ext_pulse(1'b1);
      v = NPIN'($urandom);
      wr(v, err, ack);
      chk("R7 err when free", 32'(err), 32'd0);
      e_ovr = v;
      pre  = $urandom_range(44, 60);
      post = $urandom_range(44, 56);
      flip = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 15)) : -1;
      send_seq(pre, flip, post, 1'b1);
      if (seq_clean(pre, flip, post)) e_two = 1'b1;
      else                            e_own = 1'b1;
      check_state(seq_clean(pre, flip, post) ? "R2 random" : "R3 random");
    end

    done = 1;
    finish_run();
  end

endmodule